// File: doc/BRIEF.md
# Execute-in-Place Flash Access Translator

This block sits between a simple memory-mapped request/grant port and an SPI phase sequencer. Each bus access inside a fixed address window becomes one single-byte SPI flash transaction. The translator forms the device address by adding a 32-bit configurable offset to the window address. It then selects the command byte and the transfer-mode code that match the access direction, and hands the whole descriptor to the sequencer. Read data from the sequencer comes back to the bus on a one-cycle acknowledge.

There are two modes. In normal mode every access is its own chip-select frame, with command and address phases. In sequential mode the translator asks the sequencer to keep chip select asserted after the byte. A following access in the same direction at the next byte address then streams one more data byte with no command or address phase. The open frame is closed by a separate close request in these cases: a non-contiguous access, a change of direction, an idle timeout, a stop request, disabling the block, or leaving sequential mode. A byte at the last address of a 2^n-byte page is always issued with chip select released.

Top module: `xip_read_xlate`

## Requirements
- R1: After synchronous reset, bus_gnt, bus_ack, sq_start and sq_close are all low.
- R2: In normal mode (cfg_seq_mode=0) each read issues sq_start with sq_with_hdr=1, sq_hold_cs=0, sq_cmd=cfg_rd_cmd, sq_xfer=cfg_rd_xfer, sq_addr_bytes=cfg_addr_bytes, and sq_addr = bus_addr + cfg_addr_offset (modulo 2^32).
- R3: A write (bus_we=1) uses cfg_wr_cmd and cfg_wr_xfer and passes bus_wdata on sq_wdata.
- R4: On each sq_done that ends a data byte, bus_ack pulses for one cycle in the next cycle, with bus_rdata equal to sq_rdata.
- R5: In sequential mode, an access in the same direction whose device address is the previous one plus one, made while the frame is open, issues sq_start with sq_with_hdr=0 and no sq_close.
- R6: In sequential mode, an access to any other address while the frame is open first issues sq_close, and then a new transaction with sq_with_hdr=1.
- R7: The page size is 2^cfg_page_log2 bytes. A byte whose device address has all page-offset bits set is issued with sq_hold_cs=0, so the next access starts a new framed transaction without a separate close.
- R8: While the frame is open and cfg_tmo_en=1, after cfg_tmo_limit pulses of sq_tick with no access, sq_close is issued. With cfg_tmo_en=0 the frame stays open.
- R9: While cfg_stop=1 no access is granted, and an open frame is closed.
- R10: While cfg_enable=0 no access is granted and no transaction starts.
- R11: In sequential mode, a change of direction at the next address closes the open frame before the new framed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translator enable |
| cfg_stop | input | 1 | Stop request: close frame, grant nothing |
| cfg_seq_mode | input | 1 | 0 normal, 1 sequential |
| cfg_tmo_en | input | 1 | Idle timeout enable |
| cfg_rd_cmd | input | 8 | Command byte for reads |
| cfg_wr_cmd | input | 8 | Command byte for writes |
| cfg_rd_xfer | input | 4 | Transfer-mode code for reads |
| cfg_wr_xfer | input | 4 | Transfer-mode code for writes |
| cfg_page_log2 | input | 5 | Log2 of page size in bytes |
| cfg_tmo_limit | input | 8 | Idle timeout in SCLK periods |
| cfg_addr_offset | input | 32 | Offset added to the window address |
| cfg_addr_bytes | input | 2 | Address length code passed through |
| bus_req | input | 1 | Access request, held until granted |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 16 | Address inside the window |
| bus_wdata | input | 8 | Write byte |
| bus_gnt | output | 1 | Request accepted (one cycle) |
| bus_ack | output | 1 | Access complete (one cycle) |
| bus_rdata | output | 8 | Read byte, valid with bus_ack |
| sq_start | output | 1 | Start a byte transaction (one cycle) |
| sq_close | output | 1 | Release chip select (one cycle) |
| sq_with_hdr | output | 1 | Issue command and address phases |
| sq_cmd | output | 8 | Command byte |
| sq_addr | output | 32 | Device address |
| sq_addr_bytes | output | 2 | Address length code |
| sq_xfer | output | 4 | Transfer-mode code |
| sq_hold_cs | output | 1 | Keep chip select asserted after the byte |
| sq_wdata | output | 8 | Byte to write |
| sq_done | input | 1 | Sequencer finished the start or close |
| sq_rdata | input | 8 | Byte read, valid with sq_done |
| sq_tick | input | 1 | One pulse per SCLK period |

## Verification
On every cycle the assertions check several rules. Start and close requests never coincide, and each start is a single-cycle pulse. A grant needs the block enabled and not stopped. A header-free start follows an open frame at exactly the next address, and a framed start happens only with chip select released. A page-final byte never holds chip select. Each acknowledge follows a sequencer completion. Other behaviours depend on a sequence of accesses and idle time, so only the bench scenarios show them. These are the command and mode selection per direction, the read data path, the timeout expiry with and without enable, the close that precedes a non-contiguous or reversed access, and the refusal of grants under stop or disable.

// File: rtl/xip_pkg.sv
package xip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_OPEN  = 2'd2,
    ST_CLOSE = 2'd3
  } xip_state_t;
endpackage

// File: rtl/xip_addr_map.sv
module xip_addr_map #(
  parameter int WIN_AW = 16,
  parameter int ADDR_W = 32,
  parameter int PG_W   = 5
) (
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [ADDR_W-1:0] offset,
  input  logic [PG_W-1:0]   page_log2,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] phys,
  output logic              page_end,
  output logic              follows
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask     = (ONE << page_log2) - ONE;
    phys     = {{(ADDR_W-WIN_AW){1'b0}}, win_addr} + offset;
    page_end = (phys & mask) == mask;
    follows  = (phys == last_addr + ONE) && ((phys & ~mask) == (last_addr & ~mask));
  end
endmodule

// File: rtl/xip_idle_timer.sv
module xip_idle_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic             enable,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = enable && (cnt >= limit);
endmodule

// File: rtl/xip_ctrl.sv
module xip_ctrl
  import xip_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_stop,
  input  logic              cfg_seq_mode,
  input  logic [7:0]        cfg_rd_cmd,
  input  logic [7:0]        cfg_wr_cmd,
  input  logic [3:0]        cfg_rd_xfer,
  input  logic [3:0]        cfg_wr_xfer,
  input  logic [1:0]        cfg_addr_bytes,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  input  logic [ADDR_W-1:0] phys,
  input  logic              page_end,
  input  logic              follows,
  input  logic              tmo_expired,
  input  logic              sq_done,
  input  logic [7:0]        sq_rdata,
  output logic [ADDR_W-1:0] last_addr,
  output logic              in_open,
  output logic              bus_gnt,
  output logic              bus_ack,
  output logic [7:0]        bus_rdata,
  output logic              sq_start,
  output logic              sq_close,
  output logic              sq_with_hdr,
  output logic [7:0]        sq_cmd,
  output logic [ADDR_W-1:0] sq_addr,
  output logic [1:0]        sq_addr_bytes,
  output logic [3:0]        sq_xfer,
  output logic              sq_hold_cs,
  output logic [7:0]        sq_wdata
);
  xip_state_t state;
  logic       last_we;

  assign in_open = (state == ST_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      last_addr     <= '0;
      last_we       <= 1'b0;
      bus_gnt       <= 1'b0;
      bus_ack       <= 1'b0;
      bus_rdata     <= '0;
      sq_start      <= 1'b0;
      sq_close      <= 1'b0;
      sq_with_hdr   <= 1'b0;
      sq_cmd        <= '0;
      sq_addr       <= '0;
      sq_addr_bytes <= '0;
      sq_xfer       <= '0;
      sq_hold_cs    <= 1'b0;
      sq_wdata      <= '0;
    end else begin
      bus_gnt  <= 1'b0;
      bus_ack  <= 1'b0;
      sq_start <= 1'b0;
      sq_close <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (bus_req && cfg_enable && !cfg_stop) begin
            bus_gnt       <= 1'b1;
            sq_start      <= 1'b1;
            sq_with_hdr   <= 1'b1;
            sq_cmd        <= bus_we ? cfg_wr_cmd : cfg_rd_cmd;
            sq_xfer       <= bus_we ? cfg_wr_xfer : cfg_rd_xfer;
            sq_addr       <= phys;
            sq_addr_bytes <= cfg_addr_bytes;
            sq_wdata      <= bus_wdata;
            sq_hold_cs    <= cfg_seq_mode && !page_end;
            last_addr     <= phys;
            last_we       <= bus_we;
            state         <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sq_done) begin
            bus_ack   <= 1'b1;
            bus_rdata <= sq_rdata;
            state     <= sq_hold_cs ? ST_OPEN : ST_IDLE;
          end
        end
        ST_OPEN: begin
          if (!cfg_enable || cfg_stop || !cfg_seq_mode || tmo_expired) begin
            sq_close <= 1'b1;
            state    <= ST_CLOSE;
          end else if (bus_req) begin
            if (follows && (bus_we == last_we)) begin
              bus_gnt     <= 1'b1;
              sq_start    <= 1'b1;
              sq_with_hdr <= 1'b0;
              sq_addr     <= phys;
              sq_wdata    <= bus_wdata;
              sq_hold_cs  <= !page_end;
              last_addr   <= phys;
              state       <= ST_XFER;
            end else begin
              sq_close <= 1'b1;
              state    <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: begin
          if (sq_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xip_read_xlate.sv
module xip_read_xlate #(
  parameter int WIN_AW = 16,
  parameter int ADDR_W = 32,
  parameter int PG_W   = 5,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_stop,
  input  logic              cfg_seq_mode,
  input  logic              cfg_tmo_en,
  input  logic [7:0]        cfg_rd_cmd,
  input  logic [7:0]        cfg_wr_cmd,
  input  logic [3:0]        cfg_rd_xfer,
  input  logic [3:0]        cfg_wr_xfer,
  input  logic [PG_W-1:0]   cfg_page_log2,
  input  logic [TMO_W-1:0]  cfg_tmo_limit,
  input  logic [ADDR_W-1:0] cfg_addr_offset,
  input  logic [1:0]        cfg_addr_bytes,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              bus_gnt,
  output logic              bus_ack,
  output logic [7:0]        bus_rdata,
  output logic              sq_start,
  output logic              sq_close,
  output logic              sq_with_hdr,
  output logic [7:0]        sq_cmd,
  output logic [ADDR_W-1:0] sq_addr,
  output logic [1:0]        sq_addr_bytes,
  output logic [3:0]        sq_xfer,
  output logic              sq_hold_cs,
  output logic [7:0]        sq_wdata,
  input  logic              sq_done,
  input  logic [7:0]        sq_rdata,
  input  logic              sq_tick
);
  logic [ADDR_W-1:0] phys;
  logic [ADDR_W-1:0] last_addr;
  logic              page_end;
  logic              follows;
  logic              tmo_expired;
  logic              in_open;

  xip_addr_map #(.WIN_AW(WIN_AW), .ADDR_W(ADDR_W), .PG_W(PG_W)) u_map (
    .win_addr (bus_addr),
    .offset   (cfg_addr_offset),
    .page_log2(cfg_page_log2),
    .last_addr(last_addr),
    .phys     (phys),
    .page_end (page_end),
    .follows  (follows)
  );

  xip_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (!in_open),
    .tick   (sq_tick),
    .enable (cfg_tmo_en),
    .limit  (cfg_tmo_limit),
    .expired(tmo_expired)
  );

  xip_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cfg_enable    (cfg_enable),
    .cfg_stop      (cfg_stop),
    .cfg_seq_mode  (cfg_seq_mode),
    .cfg_rd_cmd    (cfg_rd_cmd),
    .cfg_wr_cmd    (cfg_wr_cmd),
    .cfg_rd_xfer   (cfg_rd_xfer),
    .cfg_wr_xfer   (cfg_wr_xfer),
    .cfg_addr_bytes(cfg_addr_bytes),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .phys          (phys),
    .page_end      (page_end),
    .follows       (follows),
    .tmo_expired   (tmo_expired),
    .sq_done       (sq_done),
    .sq_rdata      (sq_rdata),
    .last_addr     (last_addr),
    .in_open       (in_open),
    .bus_gnt       (bus_gnt),
    .bus_ack       (bus_ack),
    .bus_rdata     (bus_rdata),
    .sq_start      (sq_start),
    .sq_close      (sq_close),
    .sq_with_hdr   (sq_with_hdr),
    .sq_cmd        (sq_cmd),
    .sq_addr       (sq_addr),
    .sq_addr_bytes (sq_addr_bytes),
    .sq_xfer       (sq_xfer),
    .sq_hold_cs    (sq_hold_cs),
    .sq_wdata      (sq_wdata)
  );
endmodule

// File: rtl/xip_read_xlate_chk.sv
module xip_read_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int PG_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic              cfg_stop,
  input logic [PG_W-1:0]   cfg_page_log2,
  input logic              bus_gnt,
  input logic              bus_ack,
  input logic              sq_start,
  input logic              sq_close,
  input logic              sq_with_hdr,
  input logic [ADDR_W-1:0] sq_addr,
  input logic              sq_hold_cs,
  input logic              sq_done
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  logic              cs_open;
  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] pmask;

  assign pmask = (ONE << cfg_page_log2) - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_open   <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (sq_start) begin
        cs_open   <= sq_hold_cs;
        prev_addr <= sq_addr;
      end else if (sq_close) begin
        cs_open <= 1'b0;
      end
    end
  end

  assert_start_close_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(sq_start && sq_close));
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sq_start |=> !sq_start);
  assert_grant_allowed_R9: assert property (@(posedge clk) disable iff (rst)
    bus_gnt |-> $past(cfg_enable && !cfg_stop));
  assert_stream_next_R5: assert property (@(posedge clk) disable iff (rst)
    (sq_start && !sq_with_hdr) |-> (cs_open && sq_addr == prev_addr + ONE));
  assert_hdr_when_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (sq_start && sq_with_hdr) |-> !cs_open);
  assert_page_end_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sq_start && ((sq_addr & pmask) == pmask)) |-> !sq_hold_cs);
  assert_ack_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(sq_done));
endmodule

bind xip_read_xlate xip_read_xlate_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_enable   (cfg_enable),
  .cfg_stop     (cfg_stop),
  .cfg_page_log2(cfg_page_log2),
  .bus_gnt      (bus_gnt),
  .bus_ack      (bus_ack),
  .sq_start     (sq_start),
  .sq_close     (sq_close),
  .sq_with_hdr  (sq_with_hdr),
  .sq_addr      (sq_addr),
  .sq_hold_cs   (sq_hold_cs),
  .sq_done      (sq_done)
);

// File: tb/tb_xip_read_xlate.sv
module tb_xip_read_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OFFS = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1, cfg_stop = 1'b0, cfg_seq_mode = 1'b0, cfg_tmo_en = 1'b1;
  logic [7:0]  cfg_rd_cmd = 8'h0B, cfg_wr_cmd = 8'h02;
  logic [3:0]  cfg_rd_xfer = 4'd2, cfg_wr_xfer = 4'd1;
  logic [4:0]  cfg_page_log2 = 5'd5;
  logic [7:0]  cfg_tmo_limit = 8'd4;
  logic [31:0] cfg_addr_offset = OFFS;
  logic [1:0]  cfg_addr_bytes = 2'd2;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_gnt, bus_ack;
  logic [7:0]  bus_rdata;
  logic        sq_start, sq_close, sq_with_hdr, sq_hold_cs;
  logic [7:0]  sq_cmd, sq_wdata;
  logic [31:0] sq_addr;
  logic [1:0]  sq_addr_bytes;
  logic [3:0]  sq_xfer;
  logic        sq_done = 1'b0;
  logic [7:0]  sq_rdata = '0;
  logic        sq_tick = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xip_read_xlate dut (.*);

  int errors = 0, checks = 0;
  int n_start = 0, n_close = 0;
  logic        l_hdr, l_hold;
  logic [7:0]  l_cmd, l_wdata;
  logic [31:0] l_addr;
  logic [3:0]  l_xfer;
  logic [1:0]  l_abytes;
  logic [31:0] mdl_addr = '0;
  logic [7:0]  got_rdata;
  logic        finished = 1'b0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sequencer model
  initial begin
    forever begin
      @(negedge clk);
      if (sq_start) begin
        n_start++;
        l_hdr = sq_with_hdr; l_hold = sq_hold_cs; l_cmd = sq_cmd; l_wdata = sq_wdata;
        l_addr = sq_addr; l_xfer = sq_xfer; l_abytes = sq_addr_bytes;
        mdl_addr = sq_with_hdr ? sq_addr : mdl_addr + 32'd1;
        repeat (2) @(negedge clk);
        sq_done = 1'b1; sq_rdata = pat(mdl_addr);
        @(negedge clk);
        sq_done = 1'b0;
      end else if (sq_close) begin
        n_close++;
        repeat (2) @(negedge clk);
        sq_done = 1'b1;
        @(negedge clk);
        sq_done = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    sq_tick = ~sq_tick;
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d, output logic ok);
    logic g = 1'b0, k = 1'b0;
    bus_we = we; bus_addr = a; bus_wdata = d; bus_req = 1'b1;
    for (int i = 0; i < 60 && !g; i++) begin
      @(negedge clk);
      if (bus_gnt) g = 1'b1;
    end
    bus_req = 1'b0;
    for (int i = 0; i < 60 && g && !k; i++) begin
      @(negedge clk);
      if (bus_ack) begin k = 1'b1; got_rdata = bus_rdata; end
    end
    ok = g && k;
  endtask

  task automatic t_reset;
    chk(!bus_gnt && !bus_ack && !sq_start && !sq_close, "R1", {bus_gnt, bus_ack, sq_start, sq_close}, 0);
  endtask

  task automatic t_normal;
    logic ok;
    cfg_seq_mode = 1'b0;
    access(1'b0, 16'h0100, 8'h00, ok);
    chk(ok, "R2", ok, 1);
    chk(l_hdr && !l_hold, "R2", {l_hdr, l_hold}, 2'b10);
    chk(l_cmd == 8'h0B && l_xfer == 4'd2 && l_abytes == 2'd2, "R2", {l_cmd, l_xfer, l_abytes}, {8'h0B, 4'd2, 2'd2});
    chk(l_addr == OFFS + 32'h100, "R2", l_addr, OFFS + 32'h100);
    chk(got_rdata == pat(OFFS + 32'h100), "R4", got_rdata, pat(OFFS + 32'h100));
    access(1'b0, 16'h0101, 8'h00, ok);
    chk(l_hdr && !l_hold, "R2", {l_hdr, l_hold}, 2'b10);
    chk(got_rdata == pat(OFFS + 32'h101), "R4", got_rdata, pat(OFFS + 32'h101));
  endtask

  task automatic t_write;
    logic ok;
    access(1'b1, 16'h0200, 8'h3C, ok);
    chk(l_cmd == 8'h02 && l_xfer == 4'd1, "R3", {l_cmd, l_xfer}, {8'h02, 4'd1});
    chk(l_wdata == 8'h3C && l_addr == OFFS + 32'h200, "R3", l_wdata, 8'h3C);
  endtask

  task automatic t_stream;
    logic ok;
    int c0;
    cfg_seq_mode = 1'b1; cfg_tmo_en = 1'b0;
    access(1'b0, 16'h0040, 8'h00, ok);
    chk(l_hdr && l_hold, "R5", {l_hdr, l_hold}, 2'b11);
    c0 = n_close;
    access(1'b0, 16'h0041, 8'h00, ok);
    chk(!l_hdr && n_close == c0, "R5", {l_hdr, n_close[7:0]}, {1'b0, c0[7:0]});
    chk(got_rdata == pat(OFFS + 32'h41), "R5", got_rdata, pat(OFFS + 32'h41));
    access(1'b0, 16'h0050, 8'h00, ok);
    chk(l_hdr && n_close == c0 + 1, "R6", n_close, c0 + 1);
    chk(l_addr == OFFS + 32'h50, "R6", l_addr, OFFS + 32'h50);
    access(1'b1, 16'h0051, 8'h77, ok);
    chk(l_hdr && n_close == c0 + 2 && l_cmd == 8'h02, "R11", {l_hdr, n_close[7:0]}, {1'b1, 8'(c0 + 2)});
    repeat (4) @(negedge clk);
    access(1'b1, 16'h0052, 8'h78, ok);
    chk(!l_hdr && l_wdata == 8'h78, "R5", {l_hdr, l_wdata}, {1'b0, 8'h78});
  endtask

  task automatic t_page;
    logic ok;
    int c0;
    access(1'b0, 16'h005E, 8'h00, ok);
    chk(l_hdr && l_hold, "R7", {l_hdr, l_hold}, 2'b11);
    access(1'b0, 16'h005F, 8'h00, ok);
    chk(!l_hdr && !l_hold, "R7", {l_hdr, l_hold}, 2'b00);
    c0 = n_close;
    access(1'b0, 16'h0060, 8'h00, ok);
    chk(l_hdr && n_close == c0, "R7", {l_hdr, n_close[7:0]}, {1'b1, c0[7:0]});
    chk(got_rdata == pat(OFFS + 32'h60), "R7", got_rdata, pat(OFFS + 32'h60));
  endtask

  task automatic t_timeout;
    logic ok;
    int c0;
    access(1'b0, 16'h0090, 8'h00, ok);
    c0 = n_close;
    repeat (40) @(negedge clk);
    chk(n_close == c0, "R8", n_close, c0);
    access(1'b0, 16'h0091, 8'h00, ok);
    chk(!l_hdr, "R8", l_hdr, 0);
    cfg_tmo_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_close == c0 + 1, "R8", n_close, c0 + 1);
    access(1'b0, 16'h0092, 8'h00, ok);
    chk(l_hdr && n_close == c0 + 1, "R8", l_hdr, 1);
  endtask

  task automatic t_stop;
    logic ok, g;
    int c0, s0;
    cfg_tmo_en = 1'b0;
    access(1'b0, 16'h00A0, 8'h00, ok);
    c0 = n_close;
    cfg_stop = 1'b1;
    repeat (10) @(negedge clk);
    chk(n_close == c0 + 1, "R9", n_close, c0 + 1);
    s0 = n_start; g = 1'b0;
    bus_we = 1'b0; bus_addr = 16'h00A1; bus_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_gnt) g = 1'b1;
    end
    bus_req = 1'b0;
    chk(!g && n_start == s0, "R9", g, 0);
    cfg_stop = 1'b0;
    access(1'b0, 16'h00A1, 8'h00, ok);
    chk(ok && l_hdr, "R9", {ok, l_hdr}, 2'b11);
  endtask

  task automatic t_disable;
    logic g = 1'b0;
    int s0, c0;
    c0 = n_close;
    cfg_enable = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_close == c0 + 1, "R10", n_close, c0 + 1);
    s0 = n_start;
    bus_req = 1'b1; bus_addr = 16'h00B0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_gnt) g = 1'b1;
    end
    bus_req = 1'b0;
    chk(!g && n_start == s0, "R10", g, 0);
    cfg_enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_write();
    t_stream();
    t_page();
    t_timeout();
    t_stop();
    t_disable();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule